// File: doc/BRIEF.md
# Code Memory Lock and Verify Controller

This block guards an on-chip program memory. Three one-time lock bits set one of four cumulative protection levels. Each program-memory access the core makes is passed through a gate that grants it or refuses it at that level. Each request is an opcode fetch or a table-read instruction, and it is tagged with whether the current instruction runs from external program memory. Each request to program the array is gated the same way. Under lock, the block holds the external-access pin value that was present at reset. It raises a flag when the live pin later disagrees with the held value.

The block also decodes a pin-level verify mode that is entered while the chip is held in reset. Two port strobes choose what the mode returns. With both high it reads back code bytes from the array, and only when the lock allows it. With both low it reads back three fixed identification bytes. A refused or inactive readout drives 0xFF on the verify data bus.

The array is outside the block. The block drives its address and takes back its data byte combinationally.

Top module: `code_lock_ctrl`

## Requirements
- R1: The level comes from `lock_bits` (1 = programmed; bit 0 is the first lock bit). The highest programmed bit decides: none gives level 1, bit 0 alone gives level 2, bit 1 (bit 2 clear) gives level 3, and bit 2 gives level 4.
- R2: At level 1, every fetch request and every program request is granted.
- R3: At level 2 or 3, a table read (`tbl_read`=1) that executes from external memory (`exec_ext`=1) and targets the internal array (`tbl_tgt_int`=1) is denied. Every other fetch is granted.
- R4: At level 2 and above, every program request is denied.
- R5: At level 4, every fetch with `exec_ext`=1 is denied. Fetches with `exec_ext`=0 are granted.
- R6: While `chip_rst` is high, the held external-access value loads the pin on every clock edge. At level 1, `xa_latched` follows the live pin. At level 2 and above, `xa_latched` shows the held value and stays frozen while reset is low.
- R7: `xa_mismatch` is 1 exactly when the level is 2 or above, `chip_rst` is low and the held value differs from the live pin.
- R8: Verify mode needs all of the following: `chip_rst`=1, `vfy_strobe_n`=0, `vfy_ale`=1, `ea_pin`=1, `vfy_a14`=0 and `vfy_a15`=0. It also needs `vfy_wr_n`=`vfy_rd_n`. Otherwise `vfy_data` is 0xFF and `vfy_deny` is 0.
- R9: Code readback (both port strobes high) at level 1 returns the array byte at `vfy_addr` on `vfy_data`.
- R10: Code readback at level 2 or above sets `vfy_deny`=1 and drives 0xFF. The lock bits never appear on the bus.
- R11: Signature readback (both port strobes low) works at every level. Addresses 0x030, 0x031 and 0x032 return 0x1E, 0x80 and 0x01. Every other address returns 0xFF.
- R12: For each request, exactly one of grant and deny is high. Both are low when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| chip_rst | input | 1 | Chip reset, active high |
| lock_bits | input | 3 | One-time lock bits, 1 = programmed |
| ea_pin | input | 1 | Live external-access pin |
| fetch_req | input | 1 | Program-memory fetch request |
| exec_ext | input | 1 | Current instruction runs from external memory |
| tbl_read | input | 1 | Request is a table read (0 = opcode fetch) |
| tbl_tgt_int | input | 1 | Table-read address lies in the internal array |
| fetch_grant | output | 1 | Fetch allowed |
| fetch_deny | output | 1 | Fetch refused |
| prog_req | input | 1 | Request to program the array |
| prog_grant | output | 1 | Programming allowed |
| prog_deny | output | 1 | Programming refused |
| xa_latched | output | 1 | Effective external-access value |
| xa_mismatch | output | 1 | Held value disagrees with live pin under lock |
| vfy_strobe_n | input | 1 | Program strobe, active low |
| vfy_ale | input | 1 | Address-latch-enable level |
| vfy_a14 | input | 1 | Address bit 14 |
| vfy_a15 | input | 1 | Address bit 15 |
| vfy_wr_n | input | 1 | Write port strobe |
| vfy_rd_n | input | 1 | Read port strobe |
| vfy_addr | input | ADDR_W | Verify address |
| rom_addr | output | ADDR_W | Address to the array |
| rom_data | input | DATA_W | Byte returned by the array |
| vfy_data | output | DATA_W | Verify data bus |
| vfy_deny | output | 1 | Code readback refused |

## Verification
A program request and a table-read fetch can arrive in the same cycle, and both are judged against one lock level. The bench raises both together at level 1, level 2 and level 4 and checks each pair of grant and deny flags separately. In the same cycle it flips the external-access pin away from its held value, so the mismatch flag is judged together with the two gate decisions.

// File: rtl/lk_pkg.sv
package lk_pkg;

  typedef enum logic [1:0] {
    LVL_OPEN    = 2'd0,
    LVL_NOTAB   = 2'd1,
    LVL_NOVFY   = 2'd2,
    LVL_NOEXT   = 2'd3
  } lock_lvl_e;

  localparam logic [15:0] SIG_BASE = 16'h0030;
  localparam logic [7:0]  SIG_B0   = 8'h1E;
  localparam logic [7:0]  SIG_B1   = 8'h80;
  localparam logic [7:0]  SIG_B2   = 8'h01;
  localparam logic [7:0]  BUS_IDLE = 8'hFF;

  // Highest programmed bit sets the level.
  function automatic lock_lvl_e lvl_from_bits(input logic [2:0] b);
    if (b[2])      return LVL_NOEXT;
    else if (b[1]) return LVL_NOVFY;
    else if (b[0]) return LVL_NOTAB;
    else           return LVL_OPEN;
  endfunction

  // Identification byte lookup; off-map addresses read idle.
  function automatic logic [7:0] sig_byte(input logic [15:0] a);
    if (a == SIG_BASE)              return SIG_B0;
    else if (a == SIG_BASE + 16'd1) return SIG_B1;
    else if (a == SIG_BASE + 16'd2) return SIG_B2;
    else                            return BUS_IDLE;
  endfunction

endpackage

// File: rtl/lk_level_dec.sv
module lk_level_dec
  import lk_pkg::*;
(
  input  logic [2:0] lock_bits,
  output lock_lvl_e  lvl,
  output logic       lvl_ge2,
  output logic       lvl_ge3,
  output logic       lvl_ge4
);
  always_comb begin
    lvl     = lvl_from_bits(lock_bits);
    lvl_ge2 = (lvl != LVL_OPEN);
    lvl_ge3 = (lvl == LVL_NOVFY) || (lvl == LVL_NOEXT);
    lvl_ge4 = (lvl == LVL_NOEXT);
  end
endmodule

// File: rtl/lk_xa_hold.sv
module lk_xa_hold (
  input  logic clk,
  input  logic chip_rst,
  input  logic ea_pin,
  input  logic lvl_ge2,
  output logic xa_eff,
  output logic xa_mismatch
);
  logic xa_hold_q;

  always_ff @(posedge clk) begin
    if (chip_rst) xa_hold_q <= ea_pin;
  end

  always_comb begin
    xa_eff      = lvl_ge2 ? xa_hold_q : ea_pin;
    xa_mismatch = lvl_ge2 && !chip_rst && (xa_hold_q != ea_pin);
  end

  // R6: under lock the held value is frozen outside reset
  a_r6_hold_frozen: assert property (@(posedge clk) disable iff (chip_rst)
    lvl_ge2 |=> (!lvl_ge2 || chip_rst || $stable(xa_eff)));

  // R7: no mismatch without lock
  a_r7_open_no_flag: assert property (@(posedge clk) disable iff (chip_rst)
    !lvl_ge2 |-> !xa_mismatch);
endmodule

// File: rtl/lk_access_gate.sv
module lk_access_gate (
  input  logic clk,
  input  logic chip_rst,
  input  logic lvl_ge2,
  input  logic lvl_ge4,
  input  logic fetch_req,
  input  logic exec_ext,
  input  logic tbl_read,
  input  logic tbl_tgt_int,
  input  logic prog_req,
  output logic fetch_grant,
  output logic fetch_deny,
  output logic prog_grant,
  output logic prog_deny
);
  logic tbl_block;
  logic ext_block;
  logic fetch_ok;

  always_comb begin
    tbl_block   = lvl_ge2 && exec_ext && tbl_read && tbl_tgt_int;
    ext_block   = lvl_ge4 && exec_ext;
    fetch_ok    = !(tbl_block || ext_block);
    fetch_grant = fetch_req && fetch_ok;
    fetch_deny  = fetch_req && !fetch_ok;
    prog_grant  = prog_req && !lvl_ge2;
    prog_deny   = prog_req && lvl_ge2;
  end

  // R12: grant and deny never coincide, and each needs a request
  a_r12_fetch_excl: assert property (@(posedge clk) disable iff (chip_rst)
    (fetch_grant || fetch_deny) |-> (fetch_req && (fetch_grant != fetch_deny)));
  a_r12_prog_excl: assert property (@(posedge clk) disable iff (chip_rst)
    (prog_grant || prog_deny) |-> (prog_req && (prog_grant != prog_deny)));
  // R4: programming is refused under lock
  a_r4_prog_locked: assert property (@(posedge clk) disable iff (chip_rst)
    (lvl_ge2 && prog_req) |-> !prog_grant);
  // R5: external execution is refused at the top level
  a_r5_no_ext_exec: assert property (@(posedge clk) disable iff (chip_rst)
    (lvl_ge4 && exec_ext) |-> !fetch_grant);
endmodule

// File: rtl/lk_verify_path.sv
module lk_verify_path
  import lk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              chip_rst,
  input  logic              lvl_ge2,
  input  logic              ea_pin,
  input  logic              vfy_strobe_n,
  input  logic              vfy_ale,
  input  logic              vfy_a14,
  input  logic              vfy_a15,
  input  logic              vfy_wr_n,
  input  logic              vfy_rd_n,
  input  logic [ADDR_W-1:0] vfy_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] vfy_data,
  output logic              vfy_deny,
  output logic              code_mode,
  output logic              sig_mode
);
  localparam logic [DATA_W-1:0] IDLE = {DATA_W{1'b1}};

  logic        entry_ok;
  logic [15:0] addr_ext;

  always_comb begin
    entry_ok  = chip_rst && !vfy_strobe_n && vfy_ale && ea_pin && !vfy_a14 && !vfy_a15;
    code_mode = entry_ok && vfy_wr_n && vfy_rd_n;
    sig_mode  = entry_ok && !vfy_wr_n && !vfy_rd_n;
    addr_ext  = 16'(vfy_addr);
    rom_addr  = vfy_addr;
    vfy_deny  = code_mode && lvl_ge2;
    if (code_mode && !lvl_ge2) vfy_data = rom_data;
    else if (sig_mode)         vfy_data = DATA_W'(sig_byte(addr_ext));
    else                       vfy_data = IDLE;
  end

  // R10: a refused readout shows only the idle pattern
  a_r10_refused_idle: assert property (@(posedge clk) disable iff (!chip_rst)
    vfy_deny |-> (vfy_data == IDLE));
  // R8: outside verify mode the bus is idle
  a_r8_idle_outside: assert property (@(posedge clk) disable iff (!chip_rst)
    !(code_mode || sig_mode) |-> (vfy_data == IDLE && !vfy_deny));
  // R9: unlocked code readback mirrors the array
  a_r9_code_mirror: assert property (@(posedge clk) disable iff (!chip_rst)
    (code_mode && !lvl_ge2) |-> (vfy_data == rom_data));
endmodule

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl
  import lk_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              chip_rst,
  input  logic [2:0]        lock_bits,
  input  logic              ea_pin,
  input  logic              fetch_req,
  input  logic              exec_ext,
  input  logic              tbl_read,
  input  logic              tbl_tgt_int,
  output logic              fetch_grant,
  output logic              fetch_deny,
  input  logic              prog_req,
  output logic              prog_grant,
  output logic              prog_deny,
  output logic              xa_latched,
  output logic              xa_mismatch,
  input  logic              vfy_strobe_n,
  input  logic              vfy_ale,
  input  logic              vfy_a14,
  input  logic              vfy_a15,
  input  logic              vfy_wr_n,
  input  logic              vfy_rd_n,
  input  logic [ADDR_W-1:0] vfy_addr,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data,
  output logic [DATA_W-1:0] vfy_data,
  output logic              vfy_deny
);
  lock_lvl_e lvl;
  logic      lvl_ge2, lvl_ge3, lvl_ge4;
  logic      code_mode, sig_mode;

  lk_level_dec u_lvl (
    .lock_bits (lock_bits),
    .lvl       (lvl),
    .lvl_ge2   (lvl_ge2),
    .lvl_ge3   (lvl_ge3),
    .lvl_ge4   (lvl_ge4)
  );

  lk_xa_hold u_xa (
    .clk         (clk),
    .chip_rst    (chip_rst),
    .ea_pin      (ea_pin),
    .lvl_ge2     (lvl_ge2),
    .xa_eff      (xa_latched),
    .xa_mismatch (xa_mismatch)
  );

  lk_access_gate u_gate (
    .clk         (clk),
    .chip_rst    (chip_rst),
    .lvl_ge2     (lvl_ge2),
    .lvl_ge4     (lvl_ge4),
    .fetch_req   (fetch_req),
    .exec_ext    (exec_ext),
    .tbl_read    (tbl_read),
    .tbl_tgt_int (tbl_tgt_int),
    .prog_req    (prog_req),
    .fetch_grant (fetch_grant),
    .fetch_deny  (fetch_deny),
    .prog_grant  (prog_grant),
    .prog_deny   (prog_deny)
  );

  lk_verify_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vfy (
    .clk          (clk),
    .chip_rst     (chip_rst),
    .lvl_ge2      (lvl_ge2),
    .ea_pin       (ea_pin),
    .vfy_strobe_n (vfy_strobe_n),
    .vfy_ale      (vfy_ale),
    .vfy_a14      (vfy_a14),
    .vfy_a15      (vfy_a15),
    .vfy_wr_n     (vfy_wr_n),
    .vfy_rd_n     (vfy_rd_n),
    .vfy_addr     (vfy_addr),
    .rom_data     (rom_data),
    .rom_addr     (rom_addr),
    .vfy_data     (vfy_data),
    .vfy_deny     (vfy_deny),
    .code_mode    (code_mode),
    .sig_mode     (sig_mode)
  );

  // R1: level flags are nested
  a_r1_nested: assert property (@(posedge clk) disable iff (chip_rst)
    (lvl_ge4 |-> lvl_ge3) and (lvl_ge3 |-> lvl_ge2));
  // R11: signature mode never reports a refusal
  a_r11_sig_no_deny: assert property (@(posedge clk) disable iff (!chip_rst)
    sig_mode |-> !vfy_deny);
  // R8: the two readout modes exclude each other
  a_r8_modes_excl: assert property (@(posedge clk) disable iff (!chip_rst)
    !(code_mode && sig_mode));
endmodule

// File: tb/code_lock_ctrl_tb.sv
`timescale 1ns/100ps
module code_lock_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          chip_rst = 1'b1;
  logic [2:0]    lock_bits = 3'b000;
  logic          ea_pin = 1'b1;
  logic          fetch_req = 0, exec_ext = 0, tbl_read = 0, tbl_tgt_int = 0;
  logic          prog_req = 0;
  logic          vfy_strobe_n = 1, vfy_ale = 0, vfy_a14 = 0, vfy_a15 = 0;
  logic          vfy_wr_n = 1, vfy_rd_n = 1;
  logic [AW-1:0] vfy_addr = '0;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic          fetch_grant, fetch_deny, prog_grant, prog_deny;
  logic          xa_latched, xa_mismatch;
  logic [DW-1:0] vfy_data;
  logic          vfy_deny;

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] rom_val(input logic [AW-1:0] a);
    logic [15:0] t;
    t = 16'(a) * 16'd13 + 16'd5;
    return t[7:0] ^ t[11:4];
  endfunction

  assign rom_data = rom_val(rom_addr);

  code_lock_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic ea);
    @(negedge clk);
    chip_rst = 1'b1;
    ea_pin   = ea;
    @(negedge clk);
    chip_rst = 1'b0;
    #1;
  endtask

  task automatic fetch(input logic ee, input logic tr, input logic ti);
    fetch_req = 1; exec_ext = ee; tbl_read = tr; tbl_tgt_int = ti;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset(1'b1);
    chk("R12 idle fetch_grant", fetch_grant, 0);
    chk("R12 idle fetch_deny", fetch_deny, 0);
    chk("R12 idle prog_deny", prog_deny, 0);
    chk("R7 idle mismatch", xa_mismatch, 0);
    chk("R8 idle vfy_data", vfy_data, 8'hFF);
  endtask

  task automatic t_open();
    lock_bits = 3'b000; do_reset(1'b1);
    fetch(1, 1, 1); chk("R2 open tbl ext", {fetch_grant, fetch_deny}, 2'b10);
    fetch(1, 0, 0); chk("R2 open ext opcode", {fetch_grant, fetch_deny}, 2'b10);
    prog_req = 1; #1; chk("R2 open prog", {prog_grant, prog_deny}, 2'b10);
    prog_req = 0; fetch_req = 0; #1;
  endtask

  task automatic t_table_lock();
    for (int k = 0; k < 3; k++) begin
      lock_bits = (k == 0) ? 3'b001 : (k == 1) ? 3'b011 : 3'b010; #1;
      fetch(1, 1, 1); chk("R3 tbl ext->int denied", {fetch_grant, fetch_deny}, 2'b01);
      fetch(1, 1, 0); chk("R3 tbl ext->ext granted", {fetch_grant, fetch_deny}, 2'b10);
      fetch(0, 1, 1); chk("R3 tbl int->int granted", {fetch_grant, fetch_deny}, 2'b10);
      fetch(1, 0, 0); chk("R3 ext opcode granted", {fetch_grant, fetch_deny}, 2'b10);
    end
    fetch_req = 0; #1;
  endtask

  task automatic t_prog_lock();
    prog_req = 1;
    lock_bits = 3'b001; #1; chk("R4 prog L2", {prog_grant, prog_deny}, 2'b01);
    lock_bits = 3'b011; #1; chk("R4 prog L3", {prog_grant, prog_deny}, 2'b01);
    lock_bits = 3'b100; #1; chk("R4 R1 prog bit2 only", {prog_grant, prog_deny}, 2'b01);
    prog_req = 0; #1;
    chk("R12 prog released", {prog_grant, prog_deny}, 2'b00);
  endtask

  task automatic t_ext_lock();
    lock_bits = 3'b111;
    fetch(1, 0, 0); chk("R5 ext opcode denied", {fetch_grant, fetch_deny}, 2'b01);
    fetch(1, 1, 0); chk("R5 ext tbl denied", {fetch_grant, fetch_deny}, 2'b01);
    fetch(0, 0, 0); chk("R5 int opcode granted", {fetch_grant, fetch_deny}, 2'b10);
    lock_bits = 3'b011;
    fetch(1, 0, 0); chk("R1 L3 ext opcode granted", {fetch_grant, fetch_deny}, 2'b10);
    fetch_req = 0; #1;
  endtask

  task automatic t_xa_hold();
    lock_bits = 3'b001; do_reset(1'b0);
    ea_pin = 1; settle();
    chk("R6 locked hold 0", xa_latched, 0);
    do_reset(1'b1);
    ea_pin = 0; settle(); settle();
    chk("R6 locked hold 1", xa_latched, 1);
    lock_bits = 3'b000; #1;
    chk("R6 open follows pin", xa_latched, 0);
    ea_pin = 1; #1;
    chk("R6 open follows pin 1", xa_latched, 1);
  endtask

  task automatic t_mismatch();
    lock_bits = 3'b011; do_reset(1'b1);
    chk("R7 agree", xa_mismatch, 0);
    ea_pin = 0; #1; chk("R7 disagree", xa_mismatch, 1);
    lock_bits = 3'b000; #1; chk("R7 open no flag", xa_mismatch, 0);
    lock_bits = 3'b111; #1; chk("R7 L4 disagree", xa_mismatch, 1);
    ea_pin = 1; #1; chk("R7 agree again", xa_mismatch, 0);
  endtask

  task automatic vfy_setup(input logic sig);
    @(negedge clk);
    chip_rst = 1; ea_pin = 1; vfy_strobe_n = 0; vfy_ale = 1;
    vfy_a14 = 0; vfy_a15 = 0; vfy_wr_n = !sig; vfy_rd_n = !sig;
    #1;
  endtask

  task automatic vfy_release();
    @(negedge clk);
    vfy_strobe_n = 1; vfy_ale = 0; vfy_wr_n = 1; vfy_rd_n = 1;
    chip_rst = 0; #1;
  endtask

  task automatic t_verify_code();
    logic [AW-1:0] al [4];
    al[0] = 12'h000; al[1] = 12'h005; al[2] = 12'h123; al[3] = 12'hFFF;
    lock_bits = 3'b000; vfy_setup(0);
    for (int i = 0; i < 4; i++) begin
      vfy_addr = al[i]; #1;
      chk("R9 code byte", vfy_data, rom_val(al[i]));
      chk("R9 no deny", vfy_deny, 0);
    end
  endtask

  task automatic t_verify_refused();
    vfy_addr = 12'h005;
    lock_bits = 3'b001; #1;
    chk("R10 L2 data", vfy_data, 8'hFF); chk("R10 L2 deny", vfy_deny, 1);
    lock_bits = 3'b011; #1;
    chk("R10 L3 data", vfy_data, 8'hFF); chk("R10 L3 deny", vfy_deny, 1);
    lock_bits = 3'b111; #1;
    chk("R10 L4 data", vfy_data, 8'hFF);
  endtask

  task automatic t_signature();
    for (int lv = 0; lv < 2; lv++) begin
      lock_bits = (lv == 0) ? 3'b000 : 3'b111;
      vfy_setup(1);
      vfy_addr = 12'h030; #1; chk("R11 sig 030", vfy_data, 8'h1E);
      vfy_addr = 12'h031; #1; chk("R11 sig 031", vfy_data, 8'h80);
      vfy_addr = 12'h032; #1; chk("R11 sig 032", vfy_data, 8'h01);
      vfy_addr = 12'h033; #1; chk("R11 sig 033", vfy_data, 8'hFF);
      vfy_addr = 12'h02F; #1; chk("R11 sig 02F", vfy_data, 8'hFF);
      chk("R11 sig no deny", vfy_deny, 0);
    end
  endtask

  task automatic t_verify_entry();
    lock_bits = 3'b000; vfy_setup(0); vfy_addr = 12'h005; #1;
    chk("R8 entry ok", vfy_data, rom_val(12'h005));
    vfy_a14 = 1; #1; chk("R8 a14 high", vfy_data, 8'hFF); vfy_a14 = 0;
    vfy_a15 = 1; #1; chk("R8 a15 high", vfy_data, 8'hFF); vfy_a15 = 0;
    vfy_ale = 0; #1; chk("R8 ale low", vfy_data, 8'hFF); vfy_ale = 1;
    vfy_strobe_n = 1; #1; chk("R8 strobe high", vfy_data, 8'hFF); vfy_strobe_n = 0;
    ea_pin = 0; #1; chk("R8 ea low", vfy_data, 8'hFF); ea_pin = 1;
    vfy_wr_n = 0; #1; chk("R8 split strobes", vfy_data, 8'hFF); vfy_wr_n = 1;
    lock_bits = 3'b001; vfy_a14 = 1; #1; chk("R8 no deny outside", vfy_deny, 0);
    vfy_a14 = 0; lock_bits = 3'b000;
    chip_rst = 0; #1; chk("R8 reset low", vfy_data, 8'hFF);
    vfy_release();
  endtask

  task automatic t_coincide();
    lock_bits = 3'b001; do_reset(1'b1);
    fetch(1, 1, 1); prog_req = 1; ea_pin = 0; #1;
    chk("R3 same-cycle fetch", {fetch_grant, fetch_deny}, 2'b01);
    chk("R4 same-cycle prog", {prog_grant, prog_deny}, 2'b01);
    chk("R7 same-cycle flag", xa_mismatch, 1);
    lock_bits = 3'b000; #1;
    chk("R2 same-cycle fetch", {fetch_grant, fetch_deny}, 2'b10);
    chk("R2 same-cycle prog", {prog_grant, prog_deny}, 2'b10);
    lock_bits = 3'b111; fetch(1, 0, 0); #1;
    chk("R5 same-cycle fetch", {fetch_grant, fetch_deny}, 2'b01);
    chk("R4 same-cycle prog L4", {prog_grant, prog_deny}, 2'b01);
    fetch_req = 0; prog_req = 0; ea_pin = 1; #1;
  endtask

  initial begin
    t_reset_state();
    t_open();
    t_table_lock();
    t_prog_lock();
    t_ext_lock();
    t_xa_hold();
    t_mismatch();
    t_verify_code();
    t_verify_refused();
    vfy_release();
    t_signature();
    vfy_release();
    t_verify_entry();
    t_coincide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule